// File: doc/BRIEF.md
# Compact Register ALU Executor

This block executes the register-to-register data-processing instructions of a compact 16-bit instruction encoding. It holds sixteen 32-bit registers and the four condition flags: negative, zero, carry and overflow. The lower group of instructions works on registers 0 to 7 and covers sixteen operations: logic, add and subtract with carry, negate, compares, multiply, and shifts and rotates by an amount held in a register. The upper group adds, compares or moves across all sixteen registers, or asks for a branch-exchange.

An instruction is presented on an 11-bit field with a valid strobe. Every operation completes in a single clock edge. A combinational observation port reads any register, and the flags are visible at all times. A branch-exchange is not carried out here. It produces a one-cycle request that carries the target register index and a link bit, and the surrounding logic acts on that request.

Top module: `compact_alu_exec`

## Requirements
- R1: After reset all sixteen registers read 0, flagsOut (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) is 0, and bxValid is 0.
- R2: An instruction is taken at a rising clock edge where opValid is 1, and its register and flag results are visible after that edge. When opValid is 0, registers, flags and bxValid do not change. opCode[10]=0 selects the lower group, where opCode[9:6] is the operation, opCode[2:0] is the destination (first operand) and opCode[5:3] is the second operand.
- R3: Lower-group codes 0 AND, 1 EOR, 12 ORR, 14 BIC (first AND NOT second), 15 MVN (NOT second) and 13 MUL (low 32 bits of the product) write the result and update only N (result bit 31) and Z. C and V keep their values.
- R4: Code 5 ADC adds with carry-in C. Code 6 SBC computes first + NOT second + C. Both write the result and set N, Z, C as the carry out (for subtraction: no borrow) and V as signed overflow.
- R5: Code 9 NEG writes 0 minus the second operand and sets the flags as a subtraction from zero, so a zero operand gives C=1.
- R6: Codes 8 TST (AND), 10 CMP (subtract) and 11 CMN (add) only update flags. The destination register is unchanged.
- R7: Codes 2 LSL, 3 LSR, 4 ASR and 7 ROR shift the first operand by bits [7:0] of the second operand. Higher bits of the second operand are ignored. An amount of 0 leaves the value and C unchanged. N and Z follow the result, V is kept, and otherwise C is the last bit shifted out.
- R8: LSL by 32 gives 0 with C = old bit 0. LSR by 32 gives 0 with C = old bit 31. LSL or LSR by more than 32 gives 0 with C=0.
- R9: ASR by 32 or more fills every bit with the old bit 31, and C takes the old bit 31.
- R10: For ROR with a nonzero amount, C is result bit 31. A nonzero amount that is a multiple of 32 leaves the value unchanged.
- R11: opCode[10]=1 selects the upper group: destination {opCode[7], opCode[2:0]}, source opCode[6:3], and opCode[9:8] = 0 ADD, 1 CMP, 2 MOV. ADD and MOV write the destination and leave all flags unchanged. CMP sets the flags as a subtraction and writes nothing.
- R12: An upper-group MOV into register 15 writes the value with bit 0 cleared. A MOV into any other register writes the value as is.
- R13: Upper-group code 3 raises bxValid for exactly one cycle after the edge, with bxIdx = opCode[6:3] and bxLink = opCode[7]. No register or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Instruction valid strobe |
| opCode | input | 11 | Instruction field |
| obsIdx | input | 4 | Register index to observe |
| obsData | output | 32 | Contents of register obsIdx |
| flagsOut | output | 4 | Flags {N, Z, C, V} |
| bxValid | output | 1 | Branch-exchange request pulse |
| bxIdx | output | 4 | Branch-exchange target register index |
| bxLink | output | 1 | Branch-exchange link bit |

## Verification
Register contents, flags and the branch-exchange request are all due at the first rising edge after opValid is sampled high. The request drops again at the following edge unless another branch-exchange is issued. The bench changes inputs on falling edges and holds each instruction for exactly one rising edge. It reads the observation port and flags at the next falling edge, half a cycle after the results settle. For the branch-exchange case it reads once more a cycle later to confirm that the pulse has ended.

// File: rtl/cax_pkg.sv
package cax_pkg;

  localparam int NUM_REGS = 16;
  localparam int IDX_W    = 4;
  localparam int OP_W     = 11;
  localparam int SHAMT_W  = 8;

  typedef enum logic [3:0] {
    FN_AND, FN_EOR, FN_ORR, FN_BIC, FN_NOT, FN_MUL, FN_ADD,
    FN_LSL, FN_LSR, FN_ASR, FN_ROR, FN_PASS
  } aluFn_e;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_FLAG
  } cinSel_e;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [IDX_W-1:0]  aIdx;
    logic [IDX_W-1:0]  bIdx;
    aluFn_e            fn;
    logic              zeroA;
    logic              invB;
    cinSel_e           cin;
    logic              updNZ;
    logic              updCV;
    logic              updShC;
    logic              clrBit0;
  } ctrlStrobe_t;

endpackage

// File: rtl/cax_ctrl.sv
module cax_ctrl
  import cax_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  output ctrlStrobe_t       strobe,
  output logic              bxValid,
  output logic [IDX_W-1:0]  bxIdx,
  output logic              bxLink
);

  localparam int PC_IDX = NUM_REGS - 1;

  logic             isHigh;
  logic [3:0]       loOp;
  logic [1:0]       hiOp;
  logic [IDX_W-1:0] loDst, loSrc, hiDst, hiSrc;

  assign isHigh = opCode[10];
  assign loOp   = opCode[9:6];
  assign hiOp   = opCode[9:8];
  assign loDst  = {1'b0, opCode[2:0]};
  assign loSrc  = {1'b0, opCode[5:3]};
  assign hiDst  = {opCode[7], opCode[2:0]};
  assign hiSrc  = opCode[6:3];

  always_comb begin
    strobe = '0;
    if (opValid) begin
      if (!isHigh) begin
        strobe.aIdx  = loDst;
        strobe.bIdx  = loSrc;
        strobe.wrIdx = loDst;
        strobe.wrEn  = 1'b1;
        strobe.updNZ = 1'b1;
        case (loOp)
          4'd0:  strobe.fn = FN_AND;
          4'd1:  strobe.fn = FN_EOR;
          4'd2:  begin strobe.fn = FN_LSL; strobe.updShC = 1'b1; end
          4'd3:  begin strobe.fn = FN_LSR; strobe.updShC = 1'b1; end
          4'd4:  begin strobe.fn = FN_ASR; strobe.updShC = 1'b1; end
          4'd5:  begin
                   strobe.fn = FN_ADD; strobe.cin = CIN_FLAG; strobe.updCV = 1'b1;
                 end
          4'd6:  begin
                   strobe.fn = FN_ADD; strobe.invB = 1'b1;
                   strobe.cin = CIN_FLAG; strobe.updCV = 1'b1;
                 end
          4'd7:  begin strobe.fn = FN_ROR; strobe.updShC = 1'b1; end
          4'd8:  begin strobe.fn = FN_AND; strobe.wrEn = 1'b0; end
          4'd9:  begin
                   strobe.fn = FN_ADD; strobe.zeroA = 1'b1; strobe.invB = 1'b1;
                   strobe.cin = CIN_ONE; strobe.updCV = 1'b1;
                 end
          4'd10: begin
                   strobe.fn = FN_ADD; strobe.invB = 1'b1; strobe.cin = CIN_ONE;
                   strobe.updCV = 1'b1; strobe.wrEn = 1'b0;
                 end
          4'd11: begin
                   strobe.fn = FN_ADD; strobe.cin = CIN_ZERO;
                   strobe.updCV = 1'b1; strobe.wrEn = 1'b0;
                 end
          4'd12: strobe.fn = FN_ORR;
          4'd13: strobe.fn = FN_MUL;
          4'd14: strobe.fn = FN_BIC;
          default: strobe.fn = FN_NOT;
        endcase
      end else begin
        strobe.aIdx  = hiDst;
        strobe.bIdx  = hiSrc;
        strobe.wrIdx = hiDst;
        case (hiOp)
          2'd0: begin strobe.fn = FN_ADD; strobe.wrEn = 1'b1; end
          2'd1: begin
                  strobe.fn = FN_ADD; strobe.invB = 1'b1; strobe.cin = CIN_ONE;
                  strobe.updNZ = 1'b1; strobe.updCV = 1'b1;
                end
          2'd2: begin
                  strobe.fn      = FN_PASS;
                  strobe.wrEn    = 1'b1;
                  strobe.clrBit0 = (hiDst == IDX_W'(PC_IDX));
                end
          default: strobe.fn = FN_AND;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bxValid <= 1'b0;
      bxIdx   <= '0;
      bxLink  <= 1'b0;
    end else begin
      bxValid <= opValid && isHigh && (hiOp == 2'd3);
      bxIdx   <= hiSrc;
      bxLink  <= opCode[7];
    end
  end

  // R2: nothing is requested without a valid instruction
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !(strobe.wrEn || strobe.updNZ || strobe.updCV || strobe.updShC));

  // R6: lower-group compares never write a register
  assert_compare_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !isHigh && (loOp == 4'd8 || loOp == 4'd10 || loOp == 4'd11))
      |-> !strobe.wrEn);

  // R13: a request pulse always follows a branch-exchange instruction
  assert_bx_source_R13: assert property (@(posedge clk) disable iff (!rstN)
    bxValid |-> ($past(opValid) && $past(isHigh) && $past(hiOp) == 2'd3));

endmodule

// File: rtl/cax_shifter.sv
module cax_shifter
  import cax_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluFn_e              fn,
  input  logic [DATA_W-1:0]   value,
  input  logic [SHAMT_W-1:0]  amt,
  input  logic                cIn,
  output logic [DATA_W-1:0]   res,
  output logic                cOut
);

  localparam int ROT_W = $clog2(DATA_W);
  localparam logic [ROT_W:0] FULL_ROT = (ROT_W+1)'(DATA_W);

  logic [DATA_W:0]        lslExt, lsrExt;
  logic signed [DATA_W:0] asrIn, asrExt;
  logic [ROT_W-1:0]       rotAmt;
  logic [DATA_W-1:0]      rotRes;

  assign lslExt = {1'b0, value} << amt;
  assign lsrExt = {value, 1'b0} >> amt;
  assign asrIn  = {value, 1'b0};
  assign asrExt = asrIn >>> amt;
  assign rotAmt = amt[ROT_W-1:0];
  assign rotRes = (value >> rotAmt) | (value << (FULL_ROT - {1'b0, rotAmt}));

  always_comb begin
    res  = value;
    cOut = cIn;
    if (amt != '0) begin
      case (fn)
        FN_LSL: begin res = lslExt[DATA_W-1:0]; cOut = lslExt[DATA_W]; end
        FN_LSR: begin res = lsrExt[DATA_W:1];   cOut = lsrExt[0];      end
        FN_ASR: begin res = asrExt[DATA_W:1];   cOut = asrExt[0];      end
        FN_ROR: begin res = rotRes;             cOut = rotRes[DATA_W-1]; end
        default: begin res = value; cOut = cIn; end
      endcase
    end
  end

endmodule

// File: rtl/cax_datapath.sv
module cax_datapath
  import cax_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  obsIdx,
  output logic [DATA_W-1:0] obsData,
  output logic [3:0]        flagsOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic flagN, flagZ, flagC, flagV;

  logic [DATA_W-1:0] opA, opB, aEff, bEff, mulRes, shRes, aluRes, wrData;
  logic [DATA_W:0]   sum;
  logic              cinBit, addV, shC;

  assign opA  = regs[strobe.aIdx];
  assign opB  = regs[strobe.bIdx];
  assign aEff = strobe.zeroA ? '0 : opA;
  assign bEff = strobe.invB ? ~opB : opB;

  always_comb begin
    case (strobe.cin)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = flagC;
      default:  cinBit = 1'b0;
    endcase
  end

  assign sum    = {1'b0, aEff} + {1'b0, bEff} + {{DATA_W{1'b0}}, cinBit};
  assign addV   = (aEff[MSB] == bEff[MSB]) && (sum[MSB] != aEff[MSB]);
  assign mulRes = opA * opB;

  cax_shifter #(.DATA_W(DATA_W)) uShift (
    .fn    (strobe.fn),
    .value (opA),
    .amt   (opB[SHAMT_W-1:0]),
    .cIn   (flagC),
    .res   (shRes),
    .cOut  (shC)
  );

  always_comb begin
    case (strobe.fn)
      FN_AND:  aluRes = opA & opB;
      FN_EOR:  aluRes = opA ^ opB;
      FN_ORR:  aluRes = opA | opB;
      FN_BIC:  aluRes = opA & ~opB;
      FN_NOT:  aluRes = ~opB;
      FN_MUL:  aluRes = mulRes;
      FN_ADD:  aluRes = sum[MSB:0];
      FN_PASS: aluRes = opB;
      default: aluRes = shRes;
    endcase
  end

  assign wrData = strobe.clrBit0 ? {aluRes[MSB:1], 1'b0} : aluRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      flagN <= 1'b0;
      flagZ <= 1'b0;
      flagC <= 1'b0;
      flagV <= 1'b0;
    end else begin
      if (strobe.wrEn) regs[strobe.wrIdx] <= wrData;
      if (strobe.updNZ) begin
        flagN <= aluRes[MSB];
        flagZ <= (aluRes == '0);
      end
      if (strobe.updCV) begin
        flagC <= sum[DATA_W];
        flagV <= addV;
      end else if (strobe.updShC) begin
        flagC <= shC;
      end
    end
  end

  assign obsData  = regs[obsIdx];
  assign flagsOut = {flagN, flagZ, flagC, flagV};

  // R11: without a flag strobe the flags hold across the edge
  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.updNZ && !strobe.updCV && !strobe.updShC) |=> $stable(flagsOut));

  // R7: a zero shift amount keeps the carry flag
  assert_zero_shift_keeps_c_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.updShC && opB[SHAMT_W-1:0] == '0) |=> $stable(flagC));

  // R12: a move into the last register leaves bit 0 clear
  assert_pc_bit0_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.clrBit0) |=> (regs[NUM_REGS-1][0] == 1'b0));

endmodule

// File: rtl/compact_alu_exec.sv
module compact_alu_exec
  import cax_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [10:0]       opCode,
  input  logic [3:0]        obsIdx,
  output logic [DATA_W-1:0] obsData,
  output logic [3:0]        flagsOut,
  output logic              bxValid,
  output logic [3:0]        bxIdx,
  output logic              bxLink
);

  ctrlStrobe_t strobe;

  cax_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe),
    .bxValid (bxValid),
    .bxIdx   (bxIdx),
    .bxLink  (bxLink)
  );

  cax_datapath #(.DATA_W(DATA_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .obsIdx   (obsIdx),
    .obsData  (obsData),
    .flagsOut (flagsOut)
  );

endmodule

// File: tb/tb_compact_alu_exec.sv
`timescale 1ns/1ps
module tb_compact_alu_exec;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [10:0] opCode = '0;
  logic [3:0]  obsIdx = '0;
  logic [31:0] obsData;
  logic [3:0]  flagsOut;
  logic        bxValid;
  logic [3:0]  bxIdx;
  logic        bxLink;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  compact_alu_exec dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .obsIdx(obsIdx), .obsData(obsData), .flagsOut(flagsOut),
    .bxValid(bxValid), .bxIdx(bxIdx), .bxLink(bxLink)
  );

  function automatic logic [10:0] lo(input int op, input int rd, input int rm);
    return {1'b0, 4'(op), 3'(rm), 3'(rd)};
  endfunction

  function automatic logic [10:0] hi(input int sel, input int rd, input int rm);
    logic [3:0] d;
    d = 4'(rd);
    return {1'b1, 2'(sel), d[3], 4'(rm), d[2:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkReg(input string tag, input int idx, input logic [31:0] exp);
    obsIdx = 4'(idx);
    #1;
    check(tag, obsData, exp);
  endtask

  task automatic checkFlags(input string tag, input logic [3:0] exp);
    check(tag, {28'd0, flagsOut}, {28'd0, exp});
  endtask

  task automatic issue(input logic [10:0] op);
    @(negedge clk);
    opValid = 1'b1;
    opCode  = op;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  // needs r6 = 1; uses upper-group adds and one EOR
  task automatic setReg(input int idx, input logic [31:0] val);
    issue(lo(1, idx, idx));
    for (int b = 31; b >= 0; b--) begin
      issue(hi(0, idx, idx));
      if (val[b]) issue(hi(0, idx, 6));
    end
  endtask

  task automatic setC();  issue(lo(10, 6, 6)); endtask
  task automatic clrC();  issue(lo(11, 6, 6)); endtask

  task automatic testReset();
    @(negedge clk);
    for (int i = 0; i < 16; i++) checkReg("R1 reg after reset", i, 32'h0);
    checkFlags("R1 flags after reset", 4'b0000);
    check("R1 bxValid after reset", {31'd0, bxValid}, 32'h0);
  endtask

  task automatic testSetupNeg();
    issue(lo(9, 1, 0));
    checkReg("R5 NEG of zero", 1, 32'h0);
    checkFlags("R5 NEG of zero flags", 4'b0110);
    issue(lo(15, 7, 7));
    checkReg("R3 MVN all ones", 7, 32'hFFFF_FFFF);
    checkFlags("R3 MVN flags", 4'b1010);
    issue(lo(9, 6, 7));
    checkReg("R5 NEG of -1", 6, 32'h1);
    checkFlags("R5 NEG of -1 flags", 4'b0000);
  endtask

  task automatic testLogic();
    setReg(1, 32'h0FF0_00FF);
    setReg(0, 32'hF0F0_1234); setC(); issue(lo(0, 0, 1));
    checkReg("R3 AND", 0, 32'h00F0_0034); checkFlags("R3 AND flags", 4'b0010);
    setReg(0, 32'hF0F0_1234); issue(lo(1, 0, 1));
    checkReg("R3 EOR", 0, 32'hFF00_12CB); checkFlags("R3 EOR flags", 4'b1010);
    setReg(0, 32'hF0F0_1234); issue(lo(12, 0, 1));
    checkReg("R3 ORR", 0, 32'hFFF0_12FF); checkFlags("R3 ORR flags", 4'b1010);
    setReg(0, 32'hF0F0_1234); issue(lo(14, 0, 1));
    checkReg("R3 BIC", 0, 32'hF000_1200); checkFlags("R3 BIC flags", 4'b1010);
    issue(lo(15, 0, 1));
    checkReg("R3 MVN", 0, 32'hF00F_FF00);
    setReg(0, 32'h0001_0001); setReg(1, 32'h0001_0003); setReg(2, 32'h8000_0000);
    issue(lo(10, 2, 6));
    checkFlags("R4 CMP overflow flags", 4'b0011);
    issue(lo(13, 0, 1));
    checkReg("R3 MUL low word", 0, 32'h0004_0003);
    checkFlags("R3 MUL keeps C V", 4'b0011);
    issue(lo(1, 3, 3));
    checkFlags("R3 EOR zero keeps C V", 4'b0111);
  endtask

  task automatic testCarryArith();
    setReg(0, 32'hFFFF_FFFF); setReg(1, 32'h0); setC(); issue(lo(5, 0, 1));
    checkReg("R4 ADC wrap", 0, 32'h0); checkFlags("R4 ADC wrap flags", 4'b0110);
    setReg(0, 32'h7FFF_FFFF); setReg(1, 32'h1); clrC(); issue(lo(5, 0, 1));
    checkReg("R4 ADC overflow", 0, 32'h8000_0000); checkFlags("R4 ADC ovf flags", 4'b1001);
    setReg(0, 32'd5); setReg(1, 32'd3); setC(); issue(lo(6, 0, 1));
    checkReg("R4 SBC C=1", 0, 32'd2); checkFlags("R4 SBC C=1 flags", 4'b0010);
    setReg(0, 32'd5); setReg(1, 32'd5); clrC(); issue(lo(6, 0, 1));
    checkReg("R4 SBC C=0", 0, 32'hFFFF_FFFF); checkFlags("R4 SBC C=0 flags", 4'b1000);
  endtask

  task automatic testCompare();
    setReg(0, 32'h1234_5678); setReg(1, 32'h1234_5678); setReg(2, 32'hEDCB_A987);
    clrC();
    issue(lo(8, 0, 2));  checkFlags("R6 TST flags", 4'b0100);
    issue(lo(10, 0, 1)); checkFlags("R6 CMP flags", 4'b0110);
    issue(lo(11, 0, 2)); checkFlags("R6 CMN flags", 4'b1000);
    checkReg("R6 compares keep Rd", 0, 32'h1234_5678);
    checkReg("R6 compares keep Rm", 2, 32'hEDCB_A987);
  endtask

  task automatic shiftCase(input string tag, input int op, input logic [31:0] a,
                           input logic [31:0] amt, input bit cSet,
                           input logic [31:0] expR, input logic [3:0] expF);
    setReg(0, a); setReg(1, amt);
    if (cSet) setC(); else clrC();
    issue(lo(op, 0, 1));
    checkReg(tag, 0, expR);
    checkFlags({tag, " flags"}, expF);
  endtask

  task automatic testShiftSmall();
    shiftCase("R7 LSL low byte amount", 2, 32'h9000_0011, 32'h104, 1'b0, 32'h0000_0110, 4'b0010);
    shiftCase("R7 LSL amount 0", 2, 32'h9000_0011, 32'h100, 1'b1, 32'h9000_0011, 4'b1010);
    shiftCase("R7 LSR amount 0", 3, 32'h9000_0011, 32'h100, 1'b0, 32'h9000_0011, 4'b1000);
    shiftCase("R7 LSR by 1", 3, 32'h8000_0011, 32'h1, 1'b0, 32'h4000_0008, 4'b0010);
  endtask

  task automatic testShiftWide();
    shiftCase("R8 LSL by 32", 2, 32'h1, 32'd32, 1'b0, 32'h0, 4'b0110);
    shiftCase("R8 LSR by 32", 3, 32'h8000_0000, 32'd32, 1'b0, 32'h0, 4'b0110);
    shiftCase("R8 LSL by 33", 2, 32'hFFFF_FFFF, 32'd33, 1'b1, 32'h0, 4'b0100);
    shiftCase("R8 LSR by 200", 3, 32'hFFFF_FFFF, 32'hC8, 1'b1, 32'h0, 4'b0100);
  endtask

  task automatic testAsr();
    shiftCase("R9 ASR by 4", 4, 32'h8000_0000, 32'd4, 1'b0, 32'hF800_0000, 4'b1000);
    shiftCase("R9 ASR by 32", 4, 32'h8000_0000, 32'd32, 1'b0, 32'hFFFF_FFFF, 4'b1010);
    shiftCase("R9 ASR by 100", 4, 32'h7FFF_FFFF, 32'd100, 1'b1, 32'h0, 4'b0100);
  endtask

  task automatic testRor();
    shiftCase("R10 ROR by 4", 7, 32'h11, 32'd4, 1'b0, 32'h1000_0001, 4'b0000);
    shiftCase("R10 ROR sets C", 7, 32'hF, 32'd4, 1'b0, 32'hF000_0000, 4'b1010);
    shiftCase("R10 ROR by 32", 7, 32'h8000_0001, 32'd32, 1'b0, 32'h8000_0001, 4'b1010);
    shiftCase("R10 ROR by 64", 7, 32'h1, 32'd64, 1'b1, 32'h1, 4'b0000);
    shiftCase("R10 ROR amount 0", 7, 32'h8000_0001, 32'h100, 1'b0, 32'h8000_0001, 4'b1000);
  endtask

  task automatic testHigh();
    setReg(3, 32'd100); setC();
    issue(hi(2, 9, 3));
    checkReg("R11 MOV to r9", 9, 32'd100); checkFlags("R11 MOV no flags", 4'b0110);
    issue(hi(0, 9, 9));
    checkReg("R11 ADD r9", 9, 32'd200); checkFlags("R11 ADD no flags", 4'b0110);
    issue(hi(0, 12, 9));
    checkReg("R11 ADD r12", 12, 32'd200);
    issue(hi(1, 9, 3));
    checkFlags("R11 CMP flags", 4'b0010); checkReg("R11 CMP no write", 9, 32'd200);
  endtask

  task automatic testPcMove();
    issue(hi(2, 15, 7));
    checkReg("R12 MOV to r15 clears bit 0", 15, 32'hFFFF_FFFE);
    issue(hi(2, 14, 7));
    checkReg("R12 MOV to r14 keeps bit 0", 14, 32'hFFFF_FFFF);
  endtask

  task automatic testBranchExchange();
    logic [3:0] f0;
    f0 = flagsOut;
    issue(hi(3, 8, 13));
    check("R13 bxValid pulse", {31'd0, bxValid}, 32'h1);
    check("R13 bxIdx", {28'd0, bxIdx}, 32'd13);
    check("R13 bxLink set", {31'd0, bxLink}, 32'h1);
    checkFlags("R13 flags unchanged", f0);
    checkReg("R13 registers unchanged", 13, 32'h0);
    @(negedge clk);
    check("R13 pulse ends", {31'd0, bxValid}, 32'h0);
    issue(hi(3, 0, 4));
    check("R13 bxIdx second", {28'd0, bxIdx}, 32'd4);
    check("R13 bxLink clear", {31'd0, bxLink}, 32'h0);
  endtask

  task automatic testIdle();
    logic [3:0] f0;
    f0 = flagsOut;
    @(negedge clk);
    opValid = 1'b0;
    opCode  = lo(15, 5, 5);
    repeat (2) @(negedge clk);
    checkReg("R2 no execute without valid", 5, 32'h0);
    checkFlags("R2 flags hold without valid", f0);
    check("R2 no bx without valid", {31'd0, bxValid}, 32'h0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSetupNeg();
    testLogic();
    testCarryArith();
    testCompare();
    testShiftSmall();
    testShiftWide();
    testAsr();
    testRor();
    testHigh();
    testPcMove();
    testBranchExchange();
    testIdle();
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

endmodule